// File: doc/BRIEF.md
# Memory Error Injection Unit

This unit sits next to the write path of a memory controller. It lets software corrupt the stored check information of chosen write accesses on purpose, so that the error handling further down the chain can be tested. Each access arrives already decoded into six coordinates: DIMM index within its channel, rank, channel, bank, page and column. Every coordinate has its own compare value and its own wildcard flag. A write whose coordinates all agree with the programmed pattern, while the unit is armed, receives an XOR mask for its ECC check bits, a parity flip, or both.

Software programs the pattern, an ECC bit mask, a two-bit half select and a three-bit type field through a small synchronous register port. It then arms the unit through the enable register. All registers read back through the same port. In one-shot mode the unit disarms itself after the first corrupted write. In repeat mode it keeps corrupting every matching write until software disarms it. The XOR outputs are combinational and belong to the access presented in the same cycle.

Top module: `errinj_top`

## Requirements
- R1: After reset every match field has its wildcard set and a value of 0. The ECC mask, half select, type and enable all read 0, and no access is corrupted.
- R2: A match field whose wildcard (bit 31 of its register) is clear matches only an access coordinate equal to its stored value. A field with the wildcard set matches every value. A hit requires all six fields to match.
- R3: Corruption is delivered only for an access with accValid=1 and accWrite=1 while the unit is armed. A read access or an idle cycle gives injValid=0 with both XOR outputs at 0.
- R4: Half select bit 0 (value 1) covers the low half of the check bits and parity output bit 0. Bit 1 (value 2) covers the high half and parity output bit 1. Value 3 covers both.
- R5: Type bit 1 puts the ECC mask, restricted to the selected halves, on eccXor. Type bit 2 raises parXor for the selected halves whatever the ECC mask holds. The two bits combine freely.
- R6: With type bit 0 (repeat) clear, the enable reads 0 after the first corrupted write, and a following matching write is not corrupted.
- R7: With type bit 0 set, the enable stays 1 after a corrupted write, and every following matching write is corrupted again.
- R8: Writing any non-zero value to the enable register arms the unit, and writing 0 disarms it. The enable reads back as 1 or 0. A software write to the enable in the same cycle as a one-shot injection takes priority over the self-clear.
- R9: Register map: offsets 0 to 5 hold DIMM, rank, channel, bank, page and column, each as value in the low bits (masked to the field width) plus wildcard in bit 31. Offset 6 is the ECC mask, 7 the half select, 8 the type, 9 the enable, and other offsets read 0.
- R10: When the half select is 0, or the type has neither bit 1 nor bit 2 set, a matching write is not corrupted, and the enable is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset for writes and reads |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| accValid | input | 1 | An access is present this cycle |
| accWrite | input | 1 | The access is a write |
| accDimm | input | DIMM_W | DIMM index within the channel |
| accRank | input | RANK_W | Rank of the access |
| accChannel | input | CHAN_W | Channel of the access |
| accBank | input | BANK_W | Bank of the access |
| accPage | input | PAGE_W | Page (row) address of the access |
| accColumn | input | COL_W | Column address of the access |
| injValid | output | 1 | This access is being corrupted |
| eccXor | output | CHECK_W | XOR mask for the check bits of this access |
| parXor | output | 2 | Parity flip for the low (bit 0) and high (bit 1) half |

## Verification
The assertions take for granted that accValid, accWrite and the register strobe are known and synchronous to the clock once reset is released. They also assume that a software write to the enable register is the only way, besides a one-shot injection, to change the armed state. The bench drives every input at the falling edge and holds it for a full cycle. It never presents an access coordinate wider than its port, so the zero extension inside the unit cannot create a false match. Each register write and each access occupies its own cycle, except in the one case that deliberately collides an enable write with a one-shot injection.

// File: rtl/errinj_pkg.sv
package errinj_pkg;

  localparam int NUM_FIELDS = 6;
  localparam int ANY_BIT    = 31;

  // register offsets; fields 0..5 must stay in match-field order
  typedef enum logic [3:0] {
    REG_DIMM    = 4'd0,
    REG_RANK    = 4'd1,
    REG_CHAN    = 4'd2,
    REG_BANK    = 4'd3,
    REG_PAGE    = 4'd4,
    REG_COL     = 4'd5,
    REG_ECCMASK = 4'd6,
    REG_SECTION = 4'd7,
    REG_TYPE    = 4'd8,
    REG_ENABLE  = 4'd9
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       armed;
    logic       doEcc;
    logic       doParity;
    logic [1:0] section;
  } injCtl_t;

  function automatic int maxWidth(int a, int b, int c, int d, int e, int f);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    return m;
  endfunction

endpackage

// File: rtl/errinj_ctrl.sv
module errinj_ctrl
  import errinj_pkg::*;
#(
  parameter int NF      = 6,
  parameter int MAXW    = 16,
  parameter int CHECK_W = 16,
  parameter logic [NF-1:0][MAXW-1:0] FIELD_MASK = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic [MAXW-1:0]    fieldVal [NF],
  output logic [NF-1:0]      fieldAny,
  output logic [CHECK_W-1:0] eccMask,
  output injCtl_t            ctl,
  input  logic               fire
);

  logic [1:0] section;
  logic [2:0] typeBits;
  logic       enable;
  logic       enWrite;

  assign enWrite = regWrEn && (regAddr == REG_ENABLE);

  // one register pair per match field
  for (genvar gi = 0; gi < NF; gi++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fieldVal[gi] <= '0;
        fieldAny[gi] <= 1'b1;
      end else if (regWrEn && regAddr == 4'(gi)) begin
        fieldVal[gi] <= regWrData[MAXW-1:0] & FIELD_MASK[gi];
        fieldAny[gi] <= regWrData[ANY_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eccMask  <= '0;
      section  <= '0;
      typeBits <= '0;
    end else if (regWrEn) begin
      if (regAddr == REG_ECCMASK) eccMask  <= regWrData[CHECK_W-1:0];
      if (regAddr == REG_SECTION) section  <= regWrData[1:0];
      if (regAddr == REG_TYPE)    typeBits <= regWrData[2:0];
    end
  end

  // software write wins over the one-shot self clear
  always_ff @(posedge clk) begin
    if (!rstN)                      enable <= 1'b0;
    else if (enWrite)               enable <= |regWrData;
    else if (fire && !typeBits[0])  enable <= 1'b0;
  end

  always_comb begin
    ctl.armed    = enable;
    ctl.doEcc    = typeBits[1];
    ctl.doParity = typeBits[2];
    ctl.section  = section;
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NF; i++) begin
      if (regAddr == 4'(i)) begin
        regRdData[MAXW-1:0] = fieldVal[i];
        regRdData[ANY_BIT]  = fieldAny[i];
      end
    end
    case (regAddr)
      REG_ECCMASK: regRdData[CHECK_W-1:0] = eccMask;
      REG_SECTION: regRdData[1:0]         = section;
      REG_TYPE:    regRdData[2:0]         = typeBits;
      REG_ENABLE:  regRdData[0]           = enable;
      default: ;
    endcase
  end

  // R6: a one-shot injection disarms the unit
  a_r6_oneshot_clears: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !typeBits[0] && !enWrite) |=> !enable);

  // R7: repeat mode keeps the unit armed
  a_r7_repeat_holds: assert property (@(posedge clk) disable iff (!rstN)
    (fire && typeBits[0] && !enWrite) |=> enable);

  // R8: a non-zero enable write arms, even during a one-shot injection
  a_r8_write_arms: assert property (@(posedge clk) disable iff (!rstN)
    (enWrite && (|regWrData)) |=> enable);

  // R3: no injection while disarmed
  a_r3_fire_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> enable);

endmodule

// File: rtl/errinj_dpath.sv
module errinj_dpath
  import errinj_pkg::*;
#(
  parameter int NF      = 6,
  parameter int MAXW    = 16,
  parameter int CHECK_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic [MAXW-1:0]    accField [NF],
  input  logic [MAXW-1:0]    fieldVal [NF],
  input  logic [NF-1:0]      fieldAny,
  input  logic [CHECK_W-1:0] eccMask,
  input  injCtl_t            ctl,
  output logic               fire,
  output logic [CHECK_W-1:0] eccXor,
  output logic [1:0]         parXor
);

  localparam int HI_W = CHECK_W / 2;
  localparam int LO_W = CHECK_W - HI_W;

  logic [NF-1:0]      fieldHit;
  logic               hasEffect;
  logic [CHECK_W-1:0] halfMask;

  for (genvar gi = 0; gi < NF; gi++) begin : g_cmp
    assign fieldHit[gi] = fieldAny[gi] || (accField[gi] == fieldVal[gi]);
  end

  assign hasEffect = (ctl.doEcc || ctl.doParity) && (ctl.section != 2'b00);
  assign fire      = ctl.armed && accValid && accWrite && (&fieldHit) && hasEffect;
  assign halfMask  = {{HI_W{ctl.section[1]}}, {LO_W{ctl.section[0]}}};
  assign eccXor    = (fire && ctl.doEcc)    ? (eccMask & halfMask) : '0;
  assign parXor    = (fire && ctl.doParity) ? ctl.section          : 2'b00;

  // R3: reads and idle cycles are never corrupted
  a_r3_write_only: assert property (@(posedge clk) disable iff (!rstN)
    !(accValid && accWrite) |-> (fire == 1'b0 && eccXor == '0 && parXor == 2'b00));

  // R5: outputs stay quiet without an injection
  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !fire |-> (eccXor == '0 && parXor == 2'b00));

  // R4: a low-only select never touches the high half
  a_r4_low_only: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.section == 2'b01) |-> (eccXor[CHECK_W-1:LO_W] == '0 && !parXor[1]));

  // R2: a hit needs every non-wildcard field equal
  a_r2_all_fields: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> ($countones(fieldHit) == NF));

endmodule

// File: rtl/errinj_top.sv
module errinj_top
  import errinj_pkg::*;
#(
  parameter int DIMM_W  = 2,
  parameter int RANK_W  = 2,
  parameter int CHAN_W  = 2,
  parameter int BANK_W  = 3,
  parameter int PAGE_W  = 16,
  parameter int COL_W   = 10,
  parameter int CHECK_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic [DIMM_W-1:0]  accDimm,
  input  logic [RANK_W-1:0]  accRank,
  input  logic [CHAN_W-1:0]  accChannel,
  input  logic [BANK_W-1:0]  accBank,
  input  logic [PAGE_W-1:0]  accPage,
  input  logic [COL_W-1:0]   accColumn,
  output logic               injValid,
  output logic [CHECK_W-1:0] eccXor,
  output logic [1:0]         parXor
);

  localparam int NF   = NUM_FIELDS;
  localparam int MAXW = maxWidth(DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W);
  localparam logic [NF-1:0][MAXW-1:0] FIELD_MASK = {
    MAXW'((64'(1) << COL_W)  - 1),
    MAXW'((64'(1) << PAGE_W) - 1),
    MAXW'((64'(1) << BANK_W) - 1),
    MAXW'((64'(1) << CHAN_W) - 1),
    MAXW'((64'(1) << RANK_W) - 1),
    MAXW'((64'(1) << DIMM_W) - 1)
  };

  logic [MAXW-1:0]    accField [NF];
  logic [MAXW-1:0]    fieldVal [NF];
  logic [NF-1:0]      fieldAny;
  logic [CHECK_W-1:0] eccMask;
  injCtl_t            ctl;
  logic               fire;

  assign accField[0] = MAXW'(accDimm);
  assign accField[1] = MAXW'(accRank);
  assign accField[2] = MAXW'(accChannel);
  assign accField[3] = MAXW'(accBank);
  assign accField[4] = MAXW'(accPage);
  assign accField[5] = MAXW'(accColumn);

  errinj_ctrl #(
    .NF(NF), .MAXW(MAXW), .CHECK_W(CHECK_W), .FIELD_MASK(FIELD_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .fieldVal(fieldVal), .fieldAny(fieldAny), .eccMask(eccMask),
    .ctl(ctl), .fire(fire)
  );

  errinj_dpath #(
    .NF(NF), .MAXW(MAXW), .CHECK_W(CHECK_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accWrite(accWrite), .accField(accField),
    .fieldVal(fieldVal), .fieldAny(fieldAny), .eccMask(eccMask),
    .ctl(ctl), .fire(fire), .eccXor(eccXor), .parXor(parXor)
  );

  assign injValid = fire;

endmodule

// File: tb/tb_errinj_top.sv
module tb_errinj_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [1:0]  accDimm = '0;
  logic [1:0]  accRank = '0;
  logic [1:0]  accChannel = '0;
  logic [2:0]  accBank = '0;
  logic [15:0] accPage = '0;
  logic [9:0]  accColumn = '0;
  logic        injValid;
  logic [15:0] eccXor;
  logic [1:0]  parXor;

  int checks = 0;
  int fails  = 0;
  localparam int FW [6] = '{2, 2, 2, 3, 16, 10};
  logic [15:0] af [6];
  logic        obsValid;
  logic [15:0] obsEcc;
  logic [1:0]  obsPar;
  logic [31:0] rd;

  always #10 clk = ~clk;

  errinj_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .accValid(accValid),
    .accWrite(accWrite), .accDimm(accDimm), .accRank(accRank),
    .accChannel(accChannel), .accBank(accBank), .accPage(accPage),
    .accColumn(accColumn), .injValid(injValid), .eccXor(eccXor), .parXor(parXor)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a);
    @(negedge clk);
    regAddr = a;
    #1 rd = regRdData;
  endtask

  task automatic doAccess(input logic wr, input logic vld);
    @(negedge clk);
    accValid = vld; accWrite = wr;
    accDimm = af[0][1:0]; accRank = af[1][1:0]; accChannel = af[2][1:0];
    accBank = af[3][2:0]; accPage = af[4]; accColumn = af[5][9:0];
    #1;
    obsValid = injValid; obsEcc = eccXor; obsPar = parXor;
    @(posedge clk); #1;
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  function automatic logic [15:0] expEcc(input logic [1:0] sec, input logic [2:0] typ,
                                         input logic [15:0] mask);
    logic [15:0] m;
    m = '0;
    if (sec[0]) m[7:0]  = 8'hFF;
    if (sec[1]) m[15:8] = 8'hFF;
    return typ[1] ? (mask & m) : 16'h0;
  endfunction

  task automatic allAny();
    for (int i = 0; i < 6; i++) regWrite(4'(i), 32'h8000_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) af[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      regRead(4'(i)); check("R1 field reset", rd, 32'h8000_0000);
    end
    for (int i = 6; i < 10; i++) begin
      regRead(4'(i)); check("R1 control reset", rd, 32'h0);
    end
    doAccess(1'b1, 1'b1);
    check("R1 no inject after reset", {31'h0, obsValid}, 32'h0);

    // R9 readback and width masking
    regWrite(4'd4, 32'h0001_2345); regRead(4'd4); check("R9 page masked", rd, 32'h0000_2345);
    regWrite(4'd5, 32'h8000_0FFF); regRead(4'd5); check("R9 column masked", rd, 32'h8000_03FF);
    regWrite(4'd3, 32'h0000_000D); regRead(4'd3); check("R9 bank masked", rd, 32'h0000_0005);
    regWrite(4'd6, 32'hFFFF_A5C3); regRead(4'd6); check("R9 ecc mask", rd, 32'h0000_A5C3);
    regWrite(4'd7, 32'h0000_0003); regRead(4'd7); check("R9 section", rd, 32'h3);
    regWrite(4'd8, 32'h0000_00FF); regRead(4'd8); check("R9 type", rd, 32'h7);
    regWrite(4'd9, 32'h0000_0500); regRead(4'd9); check("R8 enable nonzero arms", rd, 32'h1);
    regRead(4'd12); check("R9 unmapped reads zero", rd, 32'h0);
    regWrite(4'd9, 32'h0); regRead(4'd9); check("R8 enable zero disarms", rd, 32'h0);

    // R2 single-field sweeps, repeat+ecc, both halves
    allAny();
    regWrite(4'd6, 32'h0000_FFFF);
    regWrite(4'd7, 32'h3);
    regWrite(4'd8, 32'h3);
    regWrite(4'd9, 32'h1);
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < (1 << FW[f]); v++) begin
        regWrite(4'(f), 32'(v));
        for (int a = 0; a < (1 << FW[f]); a++) begin
          for (int k = 0; k < 6; k++) af[k] = 16'((a * 5 + k * 3) & ((1 << FW[k]) - 1));
          af[f] = 16'(a);
          doAccess(1'b1, 1'b1);
          check("R2 field match", {31'h0, obsValid}, {31'h0, (a == v)});
        end
        regWrite(4'(f), 32'h8000_0000);
      end
    end
    // wide fields: a few values
    for (int f = 4; f < 6; f++) begin
      regWrite(4'(f), 32'h0000_0155);
      for (int a = 16'h0150; a < 16'h0158; a++) begin
        for (int k = 0; k < 6; k++) af[k] = '0;
        af[f] = 16'(a);
        doAccess(1'b1, 1'b1);
        check("R2 wide field match", {31'h0, obsValid}, {31'h0, (a == 16'h0155)});
      end
      regWrite(4'(f), 32'h8000_0000);
    end
    // all fields pinned: exact hit, then one-field misses
    begin
      logic [15:0] pin [6];
      pin = '{16'h2, 16'h1, 16'h3, 16'h6, 16'hBEEF, 16'h2A5};
      for (int k = 0; k < 6; k++) regWrite(4'(k), 32'(pin[k]));
      for (int k = 0; k < 6; k++) af[k] = pin[k];
      doAccess(1'b1, 1'b1);
      check("R2 full match hit", {31'h0, obsValid}, 32'h1);
      check("R5 full ecc mask", {16'h0, obsEcc}, 32'h0000_FFFF);
      for (int m = 0; m < 6; m++) begin
        for (int k = 0; k < 6; k++) af[k] = pin[k];
        af[m] = 16'((pin[m] + 1) & ((1 << FW[m]) - 1));
        doAccess(1'b1, 1'b1);
        check("R2 single field miss", {31'h0, obsValid}, 32'h0);
      end
      // R3 reads and idle never inject
      for (int k = 0; k < 6; k++) af[k] = pin[k];
      doAccess(1'b0, 1'b1);
      check("R3 read not corrupted", {29'h0, obsValid, obsPar}, 32'h0);
      check("R3 read ecc zero", {16'h0, obsEcc}, 32'h0);
      doAccess(1'b1, 1'b0);
      check("R3 idle not corrupted", {29'h0, obsValid, obsPar}, 32'h0);
    end
    allAny();

    // R4 R5 R6 R7 R10: every section and type
    regWrite(4'd6, 32'h0000_5A3C);
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 8; t++) begin
        logic fires;
        fires = ((t & 6) != 0) && (s != 0);
        regWrite(4'd7, 32'(s));
        regWrite(4'd8, 32'(t));
        regWrite(4'd9, 32'h1);
        for (int k = 0; k < 6; k++) af[k] = 16'(s + t);
        doAccess(1'b1, 1'b1);
        check(fires ? "R4 R5 inject valid" : "R10 no effect no inject",
              {31'h0, obsValid}, {31'h0, fires});
        check("R5 R4 ecc xor", {16'h0, obsEcc},
              {16'h0, fires ? expEcc(2'(s), 3'(t), 16'h5A3C) : 16'h0});
        check("R5 R4 parity xor", {30'h0, obsPar},
              {30'h0, (fires && t[2]) ? 2'(s) : 2'b00});
        regRead(4'd9);
        if (fires && !t[0]) check("R6 one-shot clears enable", rd, 32'h0);
        else if (fires)     check("R7 repeat keeps enable", rd, 32'h1);
        else                check("R10 enable unchanged", rd, 32'h1);
        doAccess(1'b1, 1'b1);
        if (fires && !t[0]) check("R6 second write clean", {31'h0, obsValid}, 32'h0);
        else if (fires)     check("R7 second write corrupted", {31'h0, obsValid}, 32'h1);
      end
    end

    // R5 parity independent of mask
    regWrite(4'd6, 32'h0);
    regWrite(4'd7, 32'h2);
    regWrite(4'd8, 32'h5);
    regWrite(4'd9, 32'h1);
    doAccess(1'b1, 1'b1);
    check("R5 parity with zero mask", {29'h0, obsValid, obsPar}, 32'h6);

    // R8 enable write collides with a one-shot injection
    regWrite(4'd8, 32'h2);
    regWrite(4'd6, 32'h0000_00F0);
    regWrite(4'd7, 32'h1);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd9; regWrData = 32'h1;
    accValid = 1'b1; accWrite = 1'b1;
    #1 obsValid = injValid;
    @(posedge clk); #1;
    regWrEn = 1'b0; accValid = 1'b0; accWrite = 1'b0;
    check("R8 collide inject seen", {31'h0, obsValid}, 32'h1);
    regRead(4'd9);
    check("R8 write wins over self clear", rd, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule